// File: doc/BRIEF.md
# Serial Register-Access Master

This block lets on-chip logic read and write 32-bit registers that live in a remote device reachable over a four-wire serial link. The lines are a serial clock, a data line towards the device, a data line from the device and an active-low strobe. A requester presents an 8-bit register address, a write value and a direction flag for one cycle. The block serialises the frame, paces the link clock from a programmable divider and ends with a one-cycle completion pulse. A read also returns the 32-bit word it received.

The two directions use different frame layouts. A read sends the address, then a command pulse, then clocks in the data word. A write sends the data word first, then the address, then the command pulse. The command bit travels on the one clock pulse during which the strobe is low: a low data line means read, a high one means write. Only five register addresses are legal. A request for any other address is refused with an error flag, and the link stays quiet. Right after reset the block reads the highest register once on its own, and it takes no requests until that read has finished.

Top module: `sreg_link_master`

## Requirements
- R1: While `busy` is low, `sclk` is low, `stb_n` is high and `sdo` is low. During reset the same levels hold and `done` is low.
- R2: After reset release the block runs one read frame to address 0xFF without being asked. `busy` stays high throughout that frame, `done` does not pulse for it, and requests presented during it are dropped.
- R3: A read frame sends the 8 address bits MSB first, one per `sclk` pulse. The command pulse follows with `sdo` low and `stb_n` low. Then come 32 more pulses, and `sdi` is sampled at the end of each high phase. `rdata` is the word built MSB first.
- R4: A write frame sends the 32 data bits MSB first, then the 8 address bits MSB first, then the command pulse with `sdo` high and `stb_n` low. `rdata` reads zero at its completion.
- R5: `sdo` changes only while `sclk` is low, so it is stable across every high phase. `stb_n` changes only while `sclk` is low. `stb_n` is low for exactly one pulse per frame.
- R6: The legal addresses are 0x00, 0x02, 0x08, 0x80 and 0xFF. A request for any other address is refused. In the cycle after the request, `done` and `err` are both high, `busy` stays low, `rdata` is zero and no `sclk` pulse is sent.
- R7: Every high phase and every low phase of `sclk` within a frame lasts max(`div_i`,1) system clocks. `div_i` is captured when the request is accepted.
- R8: `busy` rises in the cycle after a legal request is accepted and stays high until completion. Requests presented while `busy` is high have no effect.
- R9: `done` is a one-cycle pulse. It arrives in the same cycle that `busy` falls, and `err` is low on a successful frame. `rdata` holds its value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_i | input | 8 | Half-period of `sclk` in system clocks (0 acts as 1) |
| req_valid | input | 1 | Request strobe, sampled while `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Remote register address |
| req_wdata | input | 32 | Word to write |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused because the address is illegal (with `done`) |
| rdata | output | 32 | Word read; zero after a write or a refusal |
| sclk | output | 1 | Link clock, idles low |
| sdo | output | 1 | Data to the remote device |
| sdi | input | 1 | Data from the remote device |
| stb_n | output | 1 | Active-low strobe that qualifies the command pulse |

## Verification
The main function is driven from a table that mixes reads and writes across all five legal addresses. It uses divider values of 0, 1, 2, 3 and 5, and data words with alternating bytes, both end bits set, all ones and a single low bit. A model of the remote device on the bench shifts in every frame and stores every write. This separates the two frame orders and shows an address/data swap or a bit-order reversal. Reading back a register just written shows whether the command bit and the sampling point are right. Measured phase lengths, which must equal the clamped divider, expose off-by-one errors in the pacer. Illegal addresses, requests during the boot read and requests during a frame show that refused or dropped requests leave the link and the remote registers untouched.

// File: rtl/sreg_link_pkg.sv
package sreg_link_pkg;

  localparam int ADDR_W    = 8;
  localparam int N_LEGAL   = 5;
  localparam logic [ADDR_W-1:0] BOOT_ADDR = 8'hFF;

  // register addresses the remote device answers to
  localparam logic [ADDR_W-1:0] LEGAL_ADDR [N_LEGAL] =
    '{8'h80, 8'h08, 8'hFF, 8'h02, 8'h00};

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_CMD  = 2'd2,
    ST_RECV = 2'd3
  } seq_state_e;

endpackage

// File: rtl/sreg_rst_sync.sv
module sreg_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_s = sync_q;

endmodule

// File: rtl/sreg_addr_filter.sv
module sreg_addr_filter
  import sreg_link_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic              legal
);

  logic [N_LEGAL-1:0] hit;

  for (genvar gi = 0; gi < N_LEGAL; gi++) begin : g_cmp
    assign hit[gi] = (addr == LEGAL_ADDR[gi]);
  end

  assign legal = |hit;

endmodule

// File: rtl/sreg_half_timer.sv
module sreg_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_len,   // already clamped to >= 1
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_n;
  logic             cnt_en;

  assign tick   = run && (cnt_q == half_len - DIV_W'(1));
  assign cnt_en = run || (cnt_q != '0);

  always_comb begin
    if (!run || tick) cnt_n = '0;
    else              cnt_n = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

endmodule

// File: rtl/sreg_frame_seq.sv
module sreg_frame_seq
  import sreg_link_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              addr_ok,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              sclk,
  output logic              sdo,
  input  logic              sdi,
  output logic              stb_n
);

  localparam int FRAME_W = DATA_W + ADDR_W;
  localparam int CNT_W   = $clog2(FRAME_W);

  seq_state_e         st_q, st_n;
  logic               wr_q, wr_n;
  logic               boot_q, boot_n;
  logic               phase_q, phase_n;
  logic               sdo_q, sdo_n;
  logic               stb_q, stb_n_n;
  logic [FRAME_W-1:0] tx_q, tx_n;
  logic [DATA_W-1:0]  rx_q, rx_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [DIV_W-1:0]   div_q, div_n;
  logic               busy_q, busy_n;
  logic               done_q, done_n;
  logic               err_q, err_n;
  logic [DATA_W-1:0]  rdata_q, rdata_n;

  logic               run;
  logic               tick;
  logic               pulse_end;
  logic               launch;
  logic               launch_wr;
  logic [ADDR_W-1:0]  launch_addr;
  logic               fin;
  logic [DATA_W-1:0]  fin_data;
  logic               out_en;

  assign run = (st_q != ST_IDLE);

  sreg_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .half_len (div_q),
    .tick     (tick)
  );

  assign pulse_end = tick && phase_q;

  // launch decision: the boot read wins over any request
  always_comb begin
    launch      = 1'b0;
    launch_wr   = 1'b0;
    launch_addr = req_addr;
    if (st_q == ST_IDLE) begin
      if (boot_q) begin
        launch      = 1'b1;
        launch_addr = BOOT_ADDR;
      end else if (req_valid && addr_ok) begin
        launch    = 1'b1;
        launch_wr = req_write;
      end
    end
  end

  always_comb begin
    st_n     = st_q;
    wr_n     = wr_q;
    boot_n   = boot_q;
    phase_n  = phase_q;
    sdo_n    = sdo_q;
    stb_n_n  = stb_q;
    tx_n     = tx_q;
    rx_n     = rx_q;
    cnt_n    = cnt_q;
    div_n    = div_q;
    busy_n   = busy_q;
    done_n   = 1'b0;
    err_n    = 1'b0;
    rdata_n  = rdata_q;
    fin      = 1'b0;
    fin_data = '0;

    if (run && tick) phase_n = ~phase_q;

    unique case (st_q)
      ST_IDLE: begin
        if (launch) begin
          st_n    = ST_SEND;
          wr_n    = launch_wr;
          busy_n  = 1'b1;
          phase_n = 1'b0;
          div_n   = (div_i == '0) ? DIV_W'(1) : div_i;
          if (launch_wr) begin
            tx_n  = {req_wdata, launch_addr};
            cnt_n = CNT_W'(FRAME_W - 1);
          end else begin
            tx_n  = {launch_addr, {DATA_W{1'b0}}};
            cnt_n = CNT_W'(ADDR_W - 1);
          end
          sdo_n = tx_n[FRAME_W-1];
        end else if (req_valid && !boot_q) begin
          // illegal address: refuse without touching the link
          done_n  = 1'b1;
          err_n   = 1'b1;
          rdata_n = '0;
        end
      end

      ST_SEND: begin
        if (pulse_end) begin
          if (cnt_q == '0) begin
            st_n    = ST_CMD;
            sdo_n   = wr_q;
            stb_n_n = 1'b0;
          end else begin
            cnt_n = cnt_q - CNT_W'(1);
            tx_n  = {tx_q[FRAME_W-2:0], 1'b0};
            sdo_n = tx_q[FRAME_W-2];
          end
        end
      end

      ST_CMD: begin
        if (pulse_end) begin
          stb_n_n = 1'b1;
          sdo_n   = 1'b0;
          if (wr_q) begin
            fin = 1'b1;
          end else begin
            st_n  = ST_RECV;
            cnt_n = CNT_W'(DATA_W - 1);
          end
        end
      end

      ST_RECV: begin
        if (pulse_end) begin
          rx_n = {rx_q[DATA_W-2:0], sdi};
          if (cnt_q == '0) begin
            fin      = 1'b1;
            fin_data = rx_n;
          end else begin
            cnt_n = cnt_q - CNT_W'(1);
          end
        end
      end

      default: st_n = ST_IDLE;
    endcase

    if (fin) begin
      st_n    = ST_IDLE;
      busy_n  = 1'b0;
      sdo_n   = 1'b0;
      stb_n_n = 1'b1;
      if (boot_q) begin
        boot_n = 1'b0;
      end else begin
        done_n  = 1'b1;
        rdata_n = fin_data;
      end
    end
  end

  // frame registers only move while a frame runs or one is launched
  assign out_en = run || launch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      wr_q    <= 1'b0;
      phase_q <= 1'b0;
      sdo_q   <= 1'b0;
      stb_q   <= 1'b1;
      tx_q    <= '0;
      rx_q    <= '0;
      cnt_q   <= '0;
      div_q   <= DIV_W'(1);
    end else if (out_en) begin
      st_q    <= st_n;
      wr_q    <= wr_n;
      phase_q <= phase_n;
      sdo_q   <= sdo_n;
      stb_q   <= stb_n_n;
      tx_q    <= tx_n;
      rx_q    <= rx_n;
      cnt_q   <= cnt_n;
      div_q   <= div_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q  <= 1'b1;
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      boot_q  <= boot_n;
      busy_q  <= busy_n;
      done_q  <= done_n;
      err_q   <= err_n;
      rdata_q <= rdata_n;
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign err   = err_q;
  assign rdata = rdata_q;
  assign sclk  = phase_q;
  assign sdo   = sdo_q;
  assign stb_n = stb_q;

endmodule

// File: rtl/sreg_link_master.sv
module sreg_link_master
  import sreg_link_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              sclk,
  output logic              sdo,
  input  logic              sdi,
  output logic              stb_n
);

  logic rst_n_s;
  logic addr_ok;

  sreg_rst_sync u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  sreg_addr_filter u_filt (
    .addr  (req_addr),
    .legal (addr_ok)
  );

  sreg_frame_seq #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .div_i     (div_i),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .addr_ok   (addr_ok),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .rdata     (rdata),
    .sclk      (sclk),
    .sdo       (sdo),
    .sdi       (sdi),
    .stb_n     (stb_n)
  );

endmodule

// File: rtl/sreg_link_chk.sv
module sreg_link_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic err,
  input logic sclk,
  input logic sdo,
  input logic stb_n
);

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && stb_n && !sdo));

  // R5
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdo));

  // R5
  stb_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stb_n) || $fell(stb_n)) |-> !sclk);

  // R3
  stb_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_n |-> busy);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && !sclk && stb_n));

endmodule

bind sreg_link_master sreg_link_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .busy  (busy),
  .done  (done),
  .err   (err),
  .sclk  (sclk),
  .sdo   (sdo),
  .stb_n (stb_n)
);

// File: tb/sreg_link_master_test.sv
module sreg_link_master_test;

  logic        clk;
  logic        rst_n;
  logic [7:0]  div;
  logic        req_valid;
  logic        req_write;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic        busy, done, err, sclk, sdo, stb_n;
  logic [31:0] rdata;
  logic        sdi;

  sreg_link_master uut (
    .clk(clk), .rst_n(rst_n), .div_i(div), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .sclk(sclk), .sdo(sdo), .sdi(sdi), .stb_n(stb_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit reported = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      report();
    end
  end

  // ---------------- remote device model ----------------
  function automatic int slot(input logic [7:0] a);
    case (a)
      8'h00: return 0;
      8'h02: return 1;
      8'h08: return 2;
      8'h80: return 3;
      default: return 4;
    endcase
  endfunction

  logic [31:0] sl_mem  [5];
  logic [31:0] exp_mem [5];
  logic [39:0] sl_sr;
  int          sl_nbits, last_nbits, sl_rx, sl_rd_left, sl_frames;
  logic        sl_cmd, rd_mode;
  logic [7:0]  sl_addr;
  logic [31:0] sl_data, rd_word;

  always @(posedge sclk) begin
    if (rd_mode) begin
      sl_rx++;
      if (sl_rx == 32) rd_mode = 1'b0;
    end else if (stb_n) begin
      sl_sr = {sl_sr[38:0], sdo};
      sl_nbits++;
    end else begin
      sl_frames++;
      last_nbits = sl_nbits;
      sl_nbits   = 0;
      sl_cmd     = sdo;
      sl_addr    = sl_sr[7:0];
      if (sdo) begin
        sl_data = sl_sr[39:8];
        sl_mem[slot(sl_addr)] = sl_data;
      end else begin
        rd_word    = sl_mem[slot(sl_addr)];
        rd_mode    = 1'b1;
        sl_rx      = 0;
        sl_rd_left = 32;
      end
    end
  end

  always @(negedge sclk) begin
    if (sl_rd_left > 0) begin
      sdi = rd_word[sl_rd_left-1];
      sl_rd_left--;
    end
  end

  // ---------------- line monitor ----------------
  logic prev_sclk, prev_sdo, prev_stb;
  int   run_len, hi_min, hi_max, lo_min, lo_max, viol, done_cnt;
  bit   seen_fall;

  task automatic clear_stats();
    hi_min = 1000; hi_max = 0; lo_min = 1000; lo_max = 0; viol = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (sclk && prev_sclk && sdo !== prev_sdo) viol++;
      if (stb_n !== prev_stb && sclk) viol++;
      if (sclk === prev_sclk) run_len++;
      else begin
        if (prev_sclk) begin
          if (run_len < hi_min) hi_min = run_len;
          if (run_len > hi_max) hi_max = run_len;
        end else if (seen_fall) begin
          if (run_len < lo_min) lo_min = run_len;
          if (run_len > lo_max) lo_max = run_len;
        end
        if (!sclk) seen_fall = 1;
        run_len = 1;
      end
      if (!busy) seen_fall = 0;
    end
    prev_sclk = sclk;
    prev_sdo  = sdo;
    prev_stb  = stb_n;
  end

  // ---------------- request driver ----------------
  logic [31:0] got_rdata;
  logic        got_err, got_busy;

  task automatic do_req(input logic w, input logic [7:0] a, input logic [31:0] d,
                        input logic [7:0] dv);
    int n;
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; div = dv;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    got_busy = busy;
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      bad++; total++;
      $display("FAIL R9 actual=no-done expected=done");
    end
    got_rdata = rdata;
    got_err   = err;
  endtask

  localparam logic [48:0] VEC [10] = '{
    {1'b0, 8'hFF, 32'h0000_0000, 8'd2},
    {1'b1, 8'h00, 32'hA5A5_0F0F, 8'd1},
    {1'b0, 8'h00, 32'h0000_0000, 8'd3},
    {1'b1, 8'h02, 32'h8000_0001, 8'd0},
    {1'b0, 8'h02, 32'h0000_0000, 8'd1},
    {1'b1, 8'h80, 32'hFFFF_FFFE, 8'd2},
    {1'b0, 8'h08, 32'h0000_0000, 8'd1},
    {1'b0, 8'h80, 32'h0000_0000, 8'd2},
    {1'b1, 8'h08, 32'hFFFF_FFFF, 8'd1},
    {1'b0, 8'h08, 32'h0000_0000, 8'd5}
  };

  initial begin
    int frames0;
    sl_mem[0] = 32'h0000_1100; sl_mem[1] = 32'h0000_0022; sl_mem[2] = 32'h0000_00F6;
    sl_mem[3] = 32'h0000_0000; sl_mem[4] = 32'h2017_0611;
    exp_mem[0] = 32'h0000_1100; exp_mem[1] = 32'h0000_0022; exp_mem[2] = 32'h0000_00F6;
    exp_mem[3] = 32'h0000_0000; exp_mem[4] = 32'h2017_0611;
    sl_sr = '0; sl_nbits = 0; last_nbits = 0; sl_rx = 0; sl_rd_left = 0; sl_frames = 0;
    sl_cmd = 0; rd_mode = 0; sl_addr = '0; sl_data = '0; rd_word = '0; sdi = 1'b0;
    run_len = 0; done_cnt = 0; seen_fall = 0; clear_stats();
    rst_n = 1'b0; div = 8'd2; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;

    repeat (3) @(negedge clk);
    // R1: levels during reset
    chk("R1 reset sclk", {31'b0, sclk}, 32'd0);
    chk("R1 reset stb_n", {31'b0, stb_n}, 32'd1);
    chk("R1 reset done", {31'b0, done}, 32'd0);
    rst_n = 1'b1;

    // R2: boot read, with a request held during it
    repeat (4) @(negedge clk);
    chk("R2 busy during boot", {31'b0, busy}, 32'd1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h00; req_wdata = 32'hDEAD_BEEF;
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R2 boot frame count", sl_frames, 1);
    chk("R2 boot is read", {31'b0, sl_cmd}, 32'd0);
    chk("R2 boot address", {24'b0, sl_addr}, 32'h0000_00FF);
    chk("R2 boot address bits", last_nbits, 8);
    chk("R2 no done for boot", done_cnt, 0);
    chk("R2 dropped request left reg", sl_mem[0], 32'h0000_1100);

    // main table
    foreach (VEC[i]) begin
      logic        w;
      logic [7:0]  a, dv;
      logic [31:0] d, exp_rd;
      int          half;
      {w, a, d, dv} = VEC[i];
      half = (dv == 0) ? 1 : int'(dv);
      clear_stats();
      frames0 = sl_frames;
      do_req(w, a, d, dv);
      chk("R8 busy after accept", {31'b0, got_busy}, 32'd1);
      chk("R9 err low on success", {31'b0, got_err}, 32'd0);
      chk("R9 busy low at done", {31'b0, busy}, 32'd0);
      chk("R3 R4 one frame", sl_frames - frames0, 1);
      chk("R3 R4 command bit", {31'b0, sl_cmd}, {31'b0, w});
      chk("R3 R4 frame address", {24'b0, sl_addr}, {24'b0, a});
      if (w) begin
        exp_mem[slot(a)] = d;
        chk("R4 bits before command", last_nbits, 40);
        chk("R4 data at device", sl_data, d);
        chk("R4 rdata zero", got_rdata, 32'd0);
      end else begin
        exp_rd = exp_mem[slot(a)];
        chk("R3 bits before command", last_nbits, 8);
        chk("R3 receive pulses", sl_rx, 32);
        chk("R3 read word", got_rdata, exp_rd);
      end
      chk("R7 high min", hi_min, half);
      chk("R7 high max", hi_max, half);
      chk("R7 low min", lo_min, half);
      chk("R7 low max", lo_max, half);
      chk("R5 line order", viol, 0);
      @(negedge clk);
      chk("R9 done single", {31'b0, done}, 32'd0);
      chk("R9 rdata held", rdata, got_rdata);
    end

    // R6: illegal addresses
    foreach (VEC[k]) begin
      if (k < 3) begin
        logic [7:0] bad_a;
        bad_a = (k == 0) ? 8'h01 : (k == 1) ? 8'h7F : 8'hFE;
        frames0 = sl_frames;
        do_req(k[0], bad_a, 32'h1234_5678, 8'd1);
        chk("R6 err flag", {31'b0, got_err}, 32'd1);
        chk("R6 busy stays low", {31'b0, got_busy}, 32'd0);
        chk("R6 rdata zero", got_rdata, 32'd0);
        repeat (20) @(negedge clk);
        chk("R6 no frame", sl_frames - frames0, 0);
      end
    end

    // R8: request during a frame is ignored
    frames0 = sl_frames;
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h02; req_wdata = 32'h1111_2222; div = 8'd4;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    req_valid = 1'b1; req_addr = 8'h80; req_wdata = 32'h3333_4444;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R8 single frame", sl_frames - frames0, 1);
    do_req(1'b0, 8'h80, 32'd0, 8'd1);
    chk("R8 ignored write left reg", got_rdata, exp_mem[3]);
    do_req(1'b0, 8'h02, 32'd0, 8'd1);
    chk("R8 accepted write stored", got_rdata, 32'h1111_2222);
    repeat (5) @(negedge clk);
    chk("R1 idle sclk", {31'b0, sclk}, 32'd0);
    chk("R1 idle stb_n", {31'b0, stb_n}, 32'd1);

    report();
  end

endmodule